// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides whether a cache-block operation issued by a core may proceed, and which fault it raises if it may not. Three operations are handled: zeroing a block, cleaning or flushing a block, and invalidating a block. Each request carries the current privilege level, a flag saying whether the hart runs virtualized, and one enable bit per operation from each of three environment-configuration levels (machine, hypervisor, supervisor). The target address is aligned down to a block size that is chosen at run time as a power of two.

If the configuration allows the operation, the block asks an external translation and protection stub for permission over a one-cycle request and grant handshake. Management operations (clean/flush and invalidate) first ask for load permission and ask for store permission only when load is refused. Zeroing asks for store permission only. A zero that is granted tells the data path to write zeros over the whole block whether or not the region is cacheable. The result comes back as a one-cycle `done` pulse carrying `go` and an exception code.

Top module: `cbo_perm_gate`

## Requirements
- R1: `blk_addr` and `probe_addr` equal `req_addr` with its low k bits cleared, where k is `blk_log2` limited to at most `MAX_BLK_LOG2`.
- R2: With `priv` below machine (machine is code 3, supervisor 1, user 0) and the operation's bit in `menv_en` clear, the result is illegal instruction (code 1); at machine level no enable bit is consulted.
- R3: With `virt_on` set, the result is virtual instruction (code 2) when priv is S or U and the `henv_en` bit is clear, or when priv is U and the `senv_en` bit is clear.
- R4: With `virt_on` clear, priv U and the `senv_en` bit clear, the result is illegal instruction (code 1).
- R5: The machine check comes before the virtual check, which comes before the supervisor check; the first failing check sets the code.
- R6: The enable bit used is bit `req_op` of each enable vector, with op codes zero = 0, clean/flush = 1, invalidate = 2; op code 3 always yields illegal instruction.
- R7: A request refused by the configuration checks issues no permission probe.
- R8: A clean/flush or invalidate first issues a load probe (`probe_store` low); if it is granted, the result is `go` with code 0 and no store probe follows.
- R9: If the load probe is refused, a store probe follows; a refused store probe yields store fault (code 3) without `go`, a granted one yields `go`.
- R10: A zero operation issues only a store probe; granted gives `go`, refused gives store fault (code 3).
- R11: `done` is a one-cycle pulse per accepted request; `go` and a non-zero `exc_code` appear only together with `done`, and `go` only with code 0; after reset all outputs are low.
- R12: `req_valid` is accepted only while `busy` is low; a request raised while busy has no effect.
- R13: `probe_req` is a one-cycle pulse issued only while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | Operation: 0 zero, 1 clean/flush, 2 invalidate |
| req_addr | input | AW | Target byte address |
| blk_log2 | input | LW | Log2 of block size in bytes |
| priv | input | 2 | Privilege: 0 U, 1 S, 3 M |
| virt_on | input | 1 | Virtualization active |
| menv_en | input | 3 | Machine-level enable bits, indexed by op |
| henv_en | input | 3 | Hypervisor-level enable bits, indexed by op |
| senv_en | input | 3 | Supervisor-level enable bits, indexed by op |
| probe_req | output | 1 | Permission query pulse |
| probe_store | output | 1 | Query kind: 0 load, 1 store |
| probe_addr | output | AW | Aligned block address of the query |
| probe_gnt | input | 1 | Stub answer strobe |
| probe_ok | input | 1 | Stub answer: access permitted |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result pulse |
| go | output | 1 | Operation may proceed (with done) |
| exc_code | output | 2 | 0 none, 1 illegal, 2 virtual, 3 store fault |
| blk_addr | output | AW | Aligned block address of the request |

## Verification
The bench builds the checker with a 16-bit address and a block-size limit of 64 bytes, so a 4-bit `blk_log2` can ask for sizes above the limit and the clamp is reached, while a size field of zero leaves the address untouched. The short address keeps the expected aligned values readable in the vector table. A stub answer latency of one to four cycles covers both back-to-back and stretched handshakes, and the longer one leaves room to raise a request while the block is busy.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  localparam int NUM_OPS = 3;

  typedef enum logic [1:0] {
    OP_ZERO  = 2'd0,
    OP_CLEAN = 2'd1,
    OP_INVAL = 2'd2,
    OP_RSVD  = 2'd3
  } cbo_op_e;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_VIRT    = 2'd2,
    EXC_STORE   = 2'd3
  } cbo_exc_e;

  typedef enum logic [1:0] {
    PL_U   = 2'd0,
    PL_S   = 2'd1,
    PL_RSV = 2'd2,
    PL_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WLD  = 2'd2,
    ST_WST  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/cbo_env_gate.sv
module cbo_env_gate
  import cbo_pkg::*;
#(
  parameter int NUM_EN = NUM_OPS
) (
  input  logic [1:0]        priv,
  input  logic              virt_on,
  input  logic [NUM_EN-1:0] menv_en,
  input  logic [NUM_EN-1:0] henv_en,
  input  logic [NUM_EN-1:0] senv_en,
  input  logic [1:0]        op,
  output logic [1:0]        verdict
);
  logic known, m_b, h_b, s_b;
  logic below_m, is_u, s_or_u;
  cbo_exc_e v;

  // pick the enable bit of the requested operation at each level
  always_comb begin
    known = 1'b0;
    m_b   = 1'b0;
    h_b   = 1'b0;
    s_b   = 1'b0;
    for (int i = 0; i < NUM_EN; i++) begin
      if (op == 2'(i)) begin
        known = 1'b1;
        m_b   = menv_en[i];
        h_b   = henv_en[i];
        s_b   = senv_en[i];
      end
    end
  end

  assign below_m = (priv != PL_M);
  assign is_u    = (priv == PL_U);
  assign s_or_u  = (priv == PL_U) || (priv == PL_S);

  // fixed order: machine, then virtual, then supervisor
  always_comb begin
    if (!known)
      v = EXC_ILLEGAL;
    else if (below_m && !m_b)
      v = EXC_ILLEGAL;
    else if (virt_on && ((s_or_u && !h_b) || (is_u && !s_b)))
      v = EXC_VIRT;
    else if (is_u && !s_b)
      v = EXC_ILLEGAL;
    else
      v = EXC_NONE;
  end

  assign verdict = v;
endmodule

// File: rtl/cbo_blk_align.sv
module cbo_blk_align #(
  parameter int AW   = 64,
  parameter int LW   = 6,
  parameter int MAXL = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] lg,
  output logic [AW-1:0] aligned
);
  logic [LW-1:0] k_eff;

  assign k_eff = (lg > LW'(MAXL)) ? LW'(MAXL) : lg;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign aligned[i] = addr[i] & (LW'(i) >= k_eff);
  end
endmodule

// File: rtl/cbo_probe_seq.sv
module cbo_probe_seq
  import cbo_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op_in,
  input  logic [AW-1:0] addr_in,
  input  logic [1:0]    verdict_in,
  input  logic          probe_gnt,
  input  logic          probe_ok,
  output logic          probe_req,
  output logic          probe_store,
  output logic [AW-1:0] addr_q,
  output logic          busy,
  output logic          waiting,
  output logic          done,
  output logic          go,
  output logic [1:0]    exc
);
  seq_st_e  st;
  cbo_op_e  op_q;
  cbo_exc_e verdict_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      op_q        <= OP_ZERO;
      verdict_q   <= EXC_NONE;
      addr_q      <= '0;
      probe_req   <= 1'b0;
      probe_store <= 1'b0;
      done        <= 1'b0;
      go          <= 1'b0;
      exc         <= EXC_NONE;
    end else begin
      probe_req <= 1'b0;
      done      <= 1'b0;
      go        <= 1'b0;
      exc       <= EXC_NONE;
      case (st)
        ST_IDLE: begin
          if (start) begin
            op_q      <= cbo_op_e'(op_in);
            verdict_q <= cbo_exc_e'(verdict_in);
            addr_q    <= addr_in;
            st        <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (verdict_q != EXC_NONE) begin
            done <= 1'b1;
            exc  <= verdict_q;
            st   <= ST_IDLE;
          end else if (op_q == OP_ZERO) begin
            probe_req   <= 1'b1;
            probe_store <= 1'b1;
            st          <= ST_WST;
          end else begin
            probe_req   <= 1'b1;
            probe_store <= 1'b0;
            st          <= ST_WLD;
          end
        end
        ST_WLD: begin
          if (probe_gnt) begin
            if (probe_ok) begin
              done <= 1'b1;
              go   <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              probe_req   <= 1'b1;
              probe_store <= 1'b1;
              st          <= ST_WST;
            end
          end
        end
        ST_WST: begin
          if (probe_gnt) begin
            done <= 1'b1;
            go   <= probe_ok;
            exc  <= probe_ok ? EXC_NONE : EXC_STORE;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign waiting = (st == ST_WLD) || (st == ST_WST);
endmodule

// File: rtl/cbo_perm_gate.sv
module cbo_perm_gate
  import cbo_pkg::*;
#(
  parameter int AW           = 64,
  parameter int MAX_BLK_LOG2 = 12,
  localparam int LW          = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] blk_log2,
  input  logic [1:0]    priv,
  input  logic          virt_on,
  input  logic [2:0]    menv_en,
  input  logic [2:0]    henv_en,
  input  logic [2:0]    senv_en,
  output logic          probe_req,
  output logic          probe_store,
  output logic [AW-1:0] probe_addr,
  input  logic          probe_gnt,
  input  logic          probe_ok,
  output logic          busy,
  output logic          done,
  output logic          go,
  output logic [1:0]    exc_code,
  output logic [AW-1:0] blk_addr
);
  logic [1:0]    verdict;
  logic [AW-1:0] aligned;
  logic [AW-1:0] addr_q;
  logic          waiting;

  cbo_env_gate #(.NUM_EN(NUM_OPS)) u_env (
    .priv    (priv),
    .virt_on (virt_on),
    .menv_en (menv_en),
    .henv_en (henv_en),
    .senv_en (senv_en),
    .op      (req_op),
    .verdict (verdict)
  );

  cbo_blk_align #(.AW(AW), .LW(LW), .MAXL(MAX_BLK_LOG2)) u_align (
    .addr    (req_addr),
    .lg      (blk_log2),
    .aligned (aligned)
  );

  cbo_probe_seq #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (req_valid),
    .op_in       (req_op),
    .addr_in     (aligned),
    .verdict_in  (verdict),
    .probe_gnt   (probe_gnt),
    .probe_ok    (probe_ok),
    .probe_req   (probe_req),
    .probe_store (probe_store),
    .addr_q      (addr_q),
    .busy        (busy),
    .waiting     (waiting),
    .done        (done),
    .go          (go),
    .exc         (exc_code)
  );

  assign probe_addr = addr_q;
  assign blk_addr   = addr_q;
endmodule

// File: rtl/cbo_perm_gate_chk.sv
module cbo_perm_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       done,
  input logic       go,
  input logic [1:0] exc_code,
  input logic       probe_req,
  input logic       probe_store,
  input logic       probe_gnt,
  input logic       probe_ok,
  input logic       busy,
  input logic       waiting
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_EXC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (exc_code != 2'd0) |-> done); // R11
  AST_GO_CLEAN: assert property (@(posedge clk) disable iff (rst)
    go |-> (done && exc_code == 2'd0)); // R11
  AST_PROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    probe_req |=> !probe_req); // R13
  AST_PROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
    probe_req |-> busy); // R13
  AST_LOAD_OK_GO: assert property (@(posedge clk) disable iff (rst)
    (waiting && probe_gnt && !probe_store && probe_ok) |=> (done && go)); // R8
  AST_LOAD_DENY_STORE: assert property (@(posedge clk) disable iff (rst)
    (waiting && probe_gnt && !probe_store && !probe_ok) |=> (probe_req && probe_store)); // R9
  AST_STORE_DENY_FAULT: assert property (@(posedge clk) disable iff (rst)
    (waiting && probe_gnt && probe_store && !probe_ok) |=> (done && exc_code == 2'd3)); // R9
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy); // R12
endmodule

bind cbo_perm_gate cbo_perm_gate_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .done        (done),
  .go          (go),
  .exc_code    (exc_code),
  .probe_req   (probe_req),
  .probe_store (probe_store),
  .probe_gnt   (probe_gnt),
  .probe_ok    (probe_ok),
  .busy        (busy),
  .waiting     (waiting)
);

// File: tb/sim_cbo_perm_gate.sv
module sim_cbo_perm_gate;
  localparam int AW = 16;
  localparam int MAXL = 6;
  localparam int LW = $clog2(AW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] blk_log2 = '0;
  logic [1:0]    priv = '0;
  logic          virt_on = 1'b0;
  logic [2:0]    menv_en = '0, henv_en = '0, senv_en = '0;
  logic          probe_req, probe_store;
  logic [AW-1:0] probe_addr, blk_addr;
  logic          probe_gnt = 1'b0, probe_ok = 1'b0;
  logic          busy, done, go;
  logic [1:0]    exc_code;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cbo_perm_gate #(.AW(AW), .MAX_BLK_LOG2(MAXL)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .blk_log2(blk_log2), .priv(priv), .virt_on(virt_on),
    .menv_en(menv_en), .henv_en(henv_en), .senv_en(senv_en),
    .probe_req(probe_req), .probe_store(probe_store), .probe_addr(probe_addr),
    .probe_gnt(probe_gnt), .probe_ok(probe_ok), .busy(busy), .done(done),
    .go(go), .exc_code(exc_code), .blk_addr(blk_addr)
  );

  typedef struct packed {
    logic [1:0]  priv;
    logic        virt;
    logic [2:0]  menv;
    logic [2:0]  henv;
    logic [2:0]  senv;
    logic [1:0]  op;
    logic [15:0] addr;
    logic [3:0]  lg;
    logic        ldok;
    logic        stok;
    logic [1:0]  xexc;
    logic        xgo;
    logic [1:0]  xprb;   // bit0 load probe seen, bit1 store probe seen
    logic [15:0] xaddr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd3,1'b0,3'd0,3'd0,3'd0,2'd0,16'h1234,4'd6, 1'b1,1'b1,2'd0,1'b1,2'b10,16'h1200},
    '{2'd1,1'b0,3'd6,3'd7,3'd7,2'd0,16'h1234,4'd6, 1'b1,1'b1,2'd1,1'b0,2'b00,16'h1200},
    '{2'd0,1'b1,3'd7,3'd7,3'd6,2'd0,16'h1234,4'd6, 1'b1,1'b1,2'd2,1'b0,2'b00,16'h1200},
    '{2'd0,1'b0,3'd7,3'd7,3'd6,2'd0,16'h1234,4'd6, 1'b1,1'b1,2'd1,1'b0,2'b00,16'h1200},
    '{2'd1,1'b1,3'd7,3'd6,3'd0,2'd0,16'h1234,4'd6, 1'b1,1'b1,2'd2,1'b0,2'b00,16'h1200},
    '{2'd1,1'b1,3'd5,3'd0,3'd0,2'd1,16'h1234,4'd6, 1'b1,1'b1,2'd1,1'b0,2'b00,16'h1200},
    '{2'd0,1'b0,3'd7,3'd7,3'd7,2'd1,16'hABCD,4'd4, 1'b1,1'b1,2'd0,1'b1,2'b01,16'hABC0},
    '{2'd0,1'b0,3'd7,3'd7,3'd7,2'd1,16'h00FF,4'd0, 1'b0,1'b1,2'd0,1'b1,2'b11,16'h00FF},
    '{2'd1,1'b0,3'd7,3'd7,3'd7,2'd2,16'hFFFF,4'd15,1'b0,1'b0,2'd3,1'b0,2'b11,16'hFFC0},
    '{2'd1,1'b0,3'd7,3'd7,3'd7,2'd0,16'h8001,4'd1, 1'b1,1'b0,2'd3,1'b0,2'b10,16'h8000},
    '{2'd0,1'b1,3'd4,3'd4,3'd4,2'd2,16'h0040,4'd6, 1'b1,1'b1,2'd0,1'b1,2'b01,16'h0040},
    '{2'd0,1'b1,3'd4,3'd4,3'd4,2'd1,16'h0040,4'd6, 1'b1,1'b1,2'd1,1'b0,2'b00,16'h0040},
    '{2'd0,1'b1,3'd4,3'd4,3'd4,2'd0,16'h0040,4'd6, 1'b1,1'b1,2'd1,1'b0,2'b00,16'h0040},
    '{2'd3,1'b0,3'd7,3'd7,3'd7,2'd3,16'h0123,4'd2, 1'b1,1'b1,2'd1,1'b0,2'b00,16'h0120},
    '{2'd3,1'b0,3'd0,3'd0,3'd0,2'd2,16'h7F7F,4'd3, 1'b0,1'b1,2'd0,1'b1,2'b11,16'h7F78}
  };

  function automatic string tag_of(input int i);
    case (i)
      0:  return "R10/R2 machine zero";
      1:  return "R2/R7 machine gate";
      2:  return "R3/R5 virtual before supervisor";
      3:  return "R4 supervisor gate";
      4:  return "R3 hypervisor gate";
      5:  return "R5 machine first";
      6:  return "R8/R1 load ok";
      7:  return "R9/R1 store fallback";
      8:  return "R9/R1 store fault clamp";
      9:  return "R10 zero store fault";
      10: return "R6 inval bit";
      11: return "R6 clean bit";
      12: return "R6 zero bit";
      13: return "R6 reserved op";
      default: return "R9 machine fallback";
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_vec(input int idx, input int lat, input bit poke);
    vec_t v = VEC[idx];
    string t = tag_of(idx);
    int ndone = 0;
    int cd = 0;
    int left = 3;
    bit last_st = 1'b0;
    bit addr_bad = 1'b0;
    logic [1:0] prb = '0;
    logic [1:0] gexc = '0;
    logic ggo = 1'b0;
    logic [15:0] gaddr = '0;
    logic [15:0] bad_addr = '0;
    @(negedge clk);
    priv = v.priv; virt_on = v.virt; menv_en = v.menv; henv_en = v.henv;
    senv_en = v.senv; req_op = v.op; req_addr = v.addr; blk_log2 = v.lg;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 60; c++) begin
      probe_gnt = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          probe_gnt = 1'b1;
          probe_ok  = last_st ? v.stok : v.ldok;
        end
      end
      if (probe_req) begin
        prb |= probe_store ? 2'b10 : 2'b01;
        last_st = probe_store;
        cd = lat;
        if (probe_addr != v.xaddr) begin addr_bad = 1'b1; bad_addr = probe_addr; end
      end
      if (done) begin
        ndone++;
        gexc = exc_code; ggo = go; gaddr = blk_addr;
      end
      if (poke && c == 1) begin
        req_valid = 1'b1; req_op = 2'd3; priv = 2'd0; menv_en = 3'd0;
      end
      if (poke && c == 2) req_valid = 1'b0;
      if (ndone > 0) begin
        left--;
        if (left == 0) break;
      end
      @(negedge clk);
    end
    probe_gnt = 1'b0;
    req_valid = 1'b0;
    chk(ndone == 1, {t, " R11 single done pulse"}, ndone, 1);
    chk(gexc == v.xexc, {t, " exc_code"}, gexc, v.xexc);
    chk(ggo == v.xgo, {t, " go"}, ggo, v.xgo);
    chk(prb == v.xprb, {t, " R7 probe kinds"}, prb, v.xprb);
    chk(gaddr == v.xaddr, {t, " R1 blk_addr"}, gaddr, v.xaddr);
    chk(!addr_bad, {t, " R13 probe_addr"}, bad_addr, v.xaddr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !go && !probe_req && exc_code == 2'd0,
        "R11 reset outputs", {busy, done, go, probe_req, exc_code}, 0);
    for (int i = 0; i < NV; i++) run_vec(i, 1, 1'b0);
    // stretched handshake latency
    run_vec(7, 4, 1'b0);
    run_vec(9, 3, 1'b0);
    // R12: request raised while busy must be ignored
    run_vec(6, 4, 1'b1);
    run_vec(14, 4, 1'b1);
    @(negedge clk);
    chk(!busy, "R12 idle after busy poke", busy, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule